// File: doc/BRIEF.md
# Buffered Compare Register Loader

This block keeps one timer channel's compare value in two registers. A bus write lands in a write buffer. A second register, the active value, is the one the channel's comparator uses. The buffered value moves into the active register only at a load point. The channel mode selects the load point: output compare, edge-aligned PWM or center-aligned PWM. Two other things can change it: whether the counter clock is selected, and the enhanced-mode and sync-enable controls. In those cases the load instead waits for an external synchronization strobe that is qualified by a load-permission flag.

A pending flag records that a write has arrived since the last load. A load point with nothing pending therefore leaves the active value untouched. While the counter clock is deselected, writes go straight into the active register. The counter, the comparator, the output pin logic and the source of the synchronization strobe all sit outside this block. The block reads the counter's present value (`cnt_q`) and its next value (`cnt_d`) together with a prescaler terminal tick. The tick marks each cycle in which the counter moves.

Top module: `cmp_shadow_loader`

## Requirements
- R1: After reset the active value is zero and nothing is pending.
- R2: With `clk_sel` equal to 0 (counter clock deselected), a write sets the active value to the written data on the next clock edge. Nothing is left pending.
- R3: In output-compare mode (`ch_mode` 00), when sync-only operation is off, a pending value loads on the edge that ends a cycle with `pre_tick` high. Any counter values qualify.
- R4: In edge-aligned mode (`ch_mode` 01) with `free_run` low, a pending value loads only in a `pre_tick` cycle where `cnt_q` equals `mod_val` and `cnt_d` equals `init_val`.
- R5: In edge-aligned mode with `free_run` high, the load point is instead the wrap with `cnt_q` all ones and `cnt_d` zero. The modulo-to-initial step then does not load.
- R6: In center-aligned mode (`ch_mode` 10 or 11), a pending value loads only in a `pre_tick` cycle where `cnt_q` equals `mod_val` and `cnt_d` equals `mod_val` minus one.
- R7: When `enh_en` and `sync_en` are both 1, sync-only operation applies in every mode. Counter load points are ignored, and a pending value loads only in a cycle with `sync_load` and `load_ok` both high.
- R8: `sync_load` has no effect unless `enh_en`, `sync_en` and `load_ok` are all 1 and `clk_sel` is nonzero.
- R9: With `enh_en` 1 and `sync_en` 0, every mode uses the same counter load points as with `enh_en` 0.
- R10: A load point reached with no write since the last load leaves the active value unchanged.
- R11: A write in the same cycle as a load point loads the new data on that edge and leaves nothing pending.
- R12: Several writes before a load point keep only the last one. The active value does not change until the load point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe for the compare value |
| wr_data | input | CW | Bus write data |
| clk_sel | input | 2 | Counter clock source select, 0 means stopped |
| ch_mode | input | 2 | 00 output compare, 01 edge PWM, 10/11 center PWM |
| enh_en | input | 1 | Enhanced mode enable |
| sync_en | input | 1 | Synchronized loading enable |
| load_ok | input | 1 | Permission flag for synchronized loads |
| sync_load | input | 1 | Synchronization load strobe |
| free_run | input | 1 | Counter is free running over its full range |
| pre_tick | input | 1 | Prescaler terminal tick, counter moves this cycle |
| cnt_q | input | CW | Present counter value |
| cnt_d | input | CW | Counter value after this tick |
| mod_val | input | CW | Modulo value |
| init_val | input | CW | Initial count value |
| active_val | output | CW | Active compare value |

## Verification
Every result is due on the edge that closes the cycle containing its trigger. A write with the clock stopped, a load point with something pending, or a sync strobe that is allowed through is visible one edge later, and nothing sooner. The bench applies one stimulus per cycle, 1 ns after an edge. It clears strobes after that edge and compares `active_val` 1 ns after the following edge against a reference built from the requirements. The sweep covers all mode, enhanced, sync-enable, load-permission and clock-select combinations. For each combination it visits every kind of load point in turn, so a wrong point shows as an early or missing update at that one sample.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef enum logic [1:0] {
    MODE_OC   = 2'b00,
    MODE_EPWM = 2'b01,
    MODE_CPWM = 2'b10,
    MODE_CPW2 = 2'b11
  } ch_mode_e;
endpackage

// File: rtl/cmp_load_point.sv
module cmp_load_point
  import cmp_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    clk_sel,
  input  ch_mode_e      mode,
  input  logic          enh_en,
  input  logic          sync_en,
  input  logic          load_ok,
  input  logic          sync_load,
  input  logic          free_run,
  input  logic          pre_tick,
  input  logic [CW-1:0] cnt_q,
  input  logic [CW-1:0] cnt_d,
  input  logic [CW-1:0] mod_val,
  input  logic [CW-1:0] init_val,
  output logic          stopped,
  output logic          fire
);
  localparam logic [CW-1:0] ALL_ONES = {CW{1'b1}};
  localparam logic [CW-1:0] ZERO     = '0;
  localparam logic [CW-1:0] ONE      = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] mod_dec;
  logic          wrap_pt;
  logic          turn_pt;
  logic          cnt_pt;
  logic          sync_only;
  logic          sync_pt;

  always_comb begin
    mod_dec   = mod_val - ONE;
    stopped   = (clk_sel == 2'b00);
    wrap_pt   = free_run ? ((cnt_q == ALL_ONES) && (cnt_d == ZERO))
                         : ((cnt_q == mod_val) && (cnt_d == init_val));
    turn_pt   = (cnt_q == mod_val) && (cnt_d == mod_dec);
    unique case (mode)
      MODE_OC:   cnt_pt = pre_tick;
      MODE_EPWM: cnt_pt = pre_tick && wrap_pt;
      default:   cnt_pt = pre_tick && turn_pt;
    endcase
    sync_only = enh_en && sync_en;
    sync_pt   = sync_only && load_ok && sync_load;
    fire      = !stopped && (sync_only ? sync_pt : cnt_pt);
  end

  // R8: a strobe without permission never opens a load
  p_sync_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_en && sync_en && !load_ok) |-> !fire);
  // R7: counter points are ignored in sync-only operation
  p_sync_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_en && sync_en && !sync_load) |-> !fire);
endmodule

// File: rtl/cmp_write_buffer.sv
module cmp_write_buffer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  input  logic          stopped,
  input  logic          fire,
  output logic          pend_q,
  output logic          load_en,
  output logic [CW-1:0] load_data
);
  logic [CW-1:0] buf_q;
  logic [CW-1:0] buf_d;
  logic          pend_d;
  logic          buf_ce;
  logic          pend_ce;

  always_comb begin
    buf_ce    = wr_en;
    buf_d     = wr_data;
    pend_ce   = wr_en || fire || stopped;
    pend_d    = wr_en && !fire && !stopped;
    load_data = wr_en ? wr_data : buf_q;
    load_en   = (stopped && wr_en) || (fire && (wr_en || pend_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
    end else if (buf_ce) begin
      buf_q <= buf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_ce) begin
      pend_q <= pend_d;
    end
  end

  // R10: any load leaves nothing pending
  p_pend_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !pend_q);
  // R12: a write away from a load point is held pending
  p_pend_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !fire && !stopped) |=> pend_q);
endmodule

// File: rtl/cmp_active_reg.sv
module cmp_active_reg #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [CW-1:0] load_data,
  output logic [CW-1:0] act_q
);
  logic [CW-1:0] act_d;

  always_comb begin
    act_d = load_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (load_en) begin
      act_q <= act_d;
    end
  end
endmodule

// File: rtl/cmp_shadow_loader.sv
module cmp_shadow_loader
  import cmp_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  input  logic [1:0]    clk_sel,
  input  logic [1:0]    ch_mode,
  input  logic          enh_en,
  input  logic          sync_en,
  input  logic          load_ok,
  input  logic          sync_load,
  input  logic          free_run,
  input  logic          pre_tick,
  input  logic [CW-1:0] cnt_q,
  input  logic [CW-1:0] cnt_d,
  input  logic [CW-1:0] mod_val,
  input  logic [CW-1:0] init_val,
  output logic [CW-1:0] active_val
);
  ch_mode_e      mode;
  logic          stopped;
  logic          fire;
  logic          pend_q;
  logic          load_en;
  logic [CW-1:0] load_data;

  always_comb mode = ch_mode_e'(ch_mode);

  cmp_load_point #(.CW(CW)) u_point (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_sel  (clk_sel),
    .mode     (mode),
    .enh_en   (enh_en),
    .sync_en  (sync_en),
    .load_ok  (load_ok),
    .sync_load(sync_load),
    .free_run (free_run),
    .pre_tick (pre_tick),
    .cnt_q    (cnt_q),
    .cnt_d    (cnt_d),
    .mod_val  (mod_val),
    .init_val (init_val),
    .stopped  (stopped),
    .fire     (fire)
  );

  cmp_write_buffer #(.CW(CW)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .stopped  (stopped),
    .fire     (fire),
    .pend_q   (pend_q),
    .load_en  (load_en),
    .load_data(load_data)
  );

  cmp_active_reg #(.CW(CW)) u_act (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .load_data(load_data),
    .act_q    (active_val)
  );

  // R2: stopped counter writes straight through
  p_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'b00 && wr_en) |=> (active_val == $past(wr_data)));
  // R11: write coinciding with a load point lands at once
  p_same_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wr_en) |=> (active_val == $past(wr_data)) && !pend_q);
  // R10: nothing pending and no write keeps the active value
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !wr_en) |=> $stable(active_val));
  // R7: sync-only operation without a strobe keeps the active value
  p_sync_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_en && sync_en && clk_sel != 2'b00 && !sync_load) |=> $stable(active_val));
endmodule

// File: tb/cmp_shadow_loader_tb.sv
`timescale 1ns/100ps
module cmp_shadow_loader_tb;
  localparam int CW = 8;
  localparam logic [CW-1:0] MODV = 8'd10;
  localparam logic [CW-1:0] INITV = 8'd2;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, enh_en, sync_en, load_ok, sync_load, free_run, pre_tick;
  logic [1:0] clk_sel, ch_mode;
  logic [CW-1:0] wr_data, cnt_q, cnt_d, mod_val, init_val, active_val;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [CW-1:0] m_act, m_buf;
  bit m_pend;
  int seed = 1;

  always #2.5 clk = ~clk;

  cmp_shadow_loader #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .clk_sel(clk_sel), .ch_mode(ch_mode), .enh_en(enh_en), .sync_en(sync_en),
    .load_ok(load_ok), .sync_load(sync_load), .free_run(free_run),
    .pre_tick(pre_tick), .cnt_q(cnt_q), .cnt_d(cnt_d), .mod_val(mod_val),
    .init_val(init_val), .active_val(active_val)
  );

  function automatic bit ref_fire();
    bit pt;
    if (clk_sel == 2'b00) return 1'b0;
    if (enh_en && sync_en) return sync_load && load_ok;       // R7 R8
    if (ch_mode == 2'b00) pt = pre_tick;                       // R3
    else if (ch_mode == 2'b01)
      pt = pre_tick && (free_run ? (cnt_q == 8'hFF && cnt_d == 8'h00)
                                 : (cnt_q == mod_val && cnt_d == init_val)); // R4 R5
    else pt = pre_tick && cnt_q == mod_val && cnt_d == mod_val - 8'd1;      // R6
    return pt;
  endfunction

  task automatic check(input string tag, input logic [CW-1:0] exp);
    checks++;
    if (active_val !== exp) begin
      failures++;
      $display("FAIL %s active_val=%0h expected=%0h mode=%0d enh=%0b se=%0b lok=%0b cs=%0d",
               tag, active_val, exp, ch_mode, enh_en, sync_en, load_ok, clk_sel);
    end
  endtask

  task automatic step(input string tag);
    bit f;
    f = ref_fire();
    @(posedge clk);
    #1;
    if (clk_sel == 2'b00 && wr_en) begin
      m_act = wr_data; m_buf = wr_data; m_pend = 0;
    end else if (wr_en) begin
      m_buf = wr_data;
      if (f) begin m_act = wr_data; m_pend = 0; end
      else m_pend = 1;
    end else if (f) begin
      if (m_pend) m_act = m_buf;
      m_pend = 0;
    end
    wr_en = 0; pre_tick = 0; sync_load = 0; free_run = 0;
    check(tag, m_act);
  endtask

  function automatic logic [CW-1:0] nextv();
    seed++;
    return 8'(seed * 37 + 11);
  endfunction

  task automatic do_write();
    wr_en = 1; wr_data = nextv();
  endtask

  task automatic tick(input logic [CW-1:0] q, input logic [CW-1:0] d);
    pre_tick = 1; cnt_q = q; cnt_d = d;
  endtask

  initial begin
    rst_n = 0; wr_en = 0; wr_data = '0; clk_sel = 2'b01; ch_mode = 2'b00;
    enh_en = 0; sync_en = 0; load_ok = 0; sync_load = 0; free_run = 0;
    pre_tick = 0; cnt_q = '0; cnt_d = '0; mod_val = MODV; init_val = INITV;
    m_act = '0; m_buf = '0; m_pend = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", '0);
    rst_n = 1;
    step("R1 idle after reset");
    for (int md = 0; md < 4; md++)
      for (int en = 0; en < 2; en++)
        for (int se = 0; se < 2; se++)
          for (int lk = 0; lk < 2; lk++)
            for (int cs = 0; cs < 2; cs++) begin
              ch_mode = 2'(md); enh_en = en[0]; sync_en = se[0];
              load_ok = lk[0]; clk_sel = cs[0] ? 2'b10 : 2'b00;
              step("R10 config change");
              do_write(); step("R2 first write");
              do_write(); step("R12 second write");
              tick(8'd3, 8'd4); step("R3 R9 mid tick");
              tick(MODV, MODV - 8'd1); step("R6 turn point");
              tick(MODV, INITV); step("R4 wrap point");
              do_write(); step("R12 write");
              sync_load = 1; step("R7 R8 sync strobe");
              do_write(); step("R12 write");
              free_run = 1; tick(MODV, INITV); step("R5 no load at modulo when free");
              free_run = 1; tick(8'hFF, 8'h00); step("R5 free wrap");
              do_write(); tick(MODV, INITV); sync_load = 1; step("R11 same cycle");
              tick(MODV, INITV); sync_load = 1; step("R10 point without write");
              tick(MODV, MODV - 8'd1); step("R10 turn without write");
            end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule